// File: doc/BRIEF.md
# Dual Down-Counting Timer with Shared Interrupt

This peripheral holds two independent down-counters on a plain 32-bit register bus. Each counter has its own reload value, a control word and a read-only view of its live count. The control word chooses which of four fixed-rate count strobes advances the counter. It also chooses whether the counter is halted, reloads itself without end, or runs once and then rests at zero.

When a counter moves from 1 to 0 it sets its own raw interrupt bit. The raw bits stay set until software clears them by writing ones to an acknowledge location. A mask register selects which raw bits reach the single interrupt output. The masked bits can be read back. The interrupt line is high while any masked bit is set.

The count strobes are single-cycle clock-enable pulses produced outside the block, one per rate. Bus reads are combinational on the address. Writes take effect at the clock edge on which the write strobe is high.

Top module: `dtmr_top`

## Requirements
- R1: While reset is high, and after it is released, every readable register returns 0 and the interrupt output is low.
- R2: Reload values read back exactly as written at 0x00 (counter 0) and 0x10 (counter 1). Control words at 0x08 and 0x18 keep only bits [4:0]: [2:0] is the source code and [4:3] is the mode. The other bits read back as 0.
- R3: A write to a counter's reload value or to its control word loads its count with the reload value, using the newly written value when the reload itself is written. The count reads back at 0x04 (counter 0) or 0x14 (counter 1).
- R4: Source codes 4, 5, 6 and 7 select strobe bit 0, 1, 2 and 3 respectively. A counter that is running and has a count above 0 decrements by one on each pulse of its selected strobe. Source codes 0 to 3 and the unselected strobes do not change the count.
- R5: Mode 0 and the reserved mode 3 hold the count still whatever the strobes do.
- R6: In mode 1 (repeating), a strobe at count 1 takes the count to 0 and sets the raw bit. The next strobe reloads the reload value.
- R7: In mode 2 (single run), the counter stays at 0 after reaching it and sets no further raw bit.
- R8: Counter 0 sets raw bit 0 and counter 1 sets raw bit 1. Each counter's strobes leave the other counter's count unchanged.
- R9: The register at 0x54 reads raw bits AND the mask at 0x48 (bits [1:0]). The interrupt output is high exactly when that value is nonzero.
- R10: Writing ones to 0x4C clears the matching raw bits. A counter reaching 0 in the same cycle keeps its bit set.
- R11: Reads of any offset not named above return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 7 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| src_tick | input | 4 | Count strobes for source codes 4..7 |
| irq_out | output | 1 | Combined masked interrupt |

## Verification
Some properties are checked on every cycle. Per counter, a single decrement on each selected strobe, a frozen count in the halt modes and a resting zero in single-run mode are all checked. Raw bits must be set after a terminal count and cleared after an acknowledge that does not collide with one, and the output must be silent while the mask is empty. The bench's scenarios are needed for the rest. These are the reload on wrap and the exact readback values, the unmapped offsets, and the precedence of a terminal count over an acknowledge in the same cycle. They also include the isolation between the two counters and the restoration of state by a mid-run reset.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    localparam int BUS_W   = 32;
    localparam int ADDR_W  = 7;
    localparam int NUM_TMR = 2;
    localparam int NUM_SRC = 4;
    localparam int CTRL_W  = 5;

    localparam logic [ADDR_W-1:0] OFS_DIV0   = 7'h00;
    localparam logic [ADDR_W-1:0] OFS_CNT0   = 7'h04;
    localparam logic [ADDR_W-1:0] OFS_CTRL0  = 7'h08;
    localparam logic [ADDR_W-1:0] OFS_DIV1   = 7'h10;
    localparam logic [ADDR_W-1:0] OFS_CNT1   = 7'h14;
    localparam logic [ADDR_W-1:0] OFS_CTRL1  = 7'h18;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 7'h48;
    localparam logic [ADDR_W-1:0] OFS_ACK    = 7'h4C;
    localparam logic [ADDR_W-1:0] OFS_MASKED = 7'h54;

    typedef enum logic [1:0] {
        RUN_HALT   = 2'd0,
        RUN_REPEAT = 2'd1,
        RUN_SINGLE = 2'd2,
        RUN_RSVD   = 2'd3
    } run_mode_e;

    typedef struct packed {
        run_mode_e  mode;
        logic [2:0] src;
    } tctrl_t;

    function automatic logic strobe_of(input logic [2:0] code,
                                       input logic [NUM_SRC-1:0] ticks);
        logic s;
        case (code)
            3'd4:    s = ticks[0];
            3'd5:    s = ticks[1];
            3'd6:    s = ticks[2];
            3'd7:    s = ticks[3];
            default: s = 1'b0;
        endcase
        return s;
    endfunction

    function automatic logic mode_runs(input run_mode_e m);
        return (m == RUN_REPEAT) || (m == RUN_SINGLE);
    endfunction

endpackage

// File: rtl/dtmr_regdec.sv
module dtmr_regdec
    import dtmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                             bus_wr,
    input  logic [ADDR_W-1:0]                bus_addr,
    output logic [NUM_TMR-1:0]               wr_div,
    output logic [NUM_TMR-1:0]               wr_ctrl,
    output logic                             wr_mask,
    output logic                             wr_ack,
    input  logic [NUM_TMR-1:0][DW-1:0]       div_q,
    input  logic [NUM_TMR-1:0][DW-1:0]       cnt_q,
    input  logic [NUM_TMR-1:0][CTRL_W-1:0]   ctrl_q,
    input  logic [NUM_TMR-1:0]               mask_q,
    input  logic [NUM_TMR-1:0]               masked,
    output logic [BUS_W-1:0]                 bus_rdata
);

    always_comb begin
        wr_div  = '0;
        wr_ctrl = '0;
        wr_mask = 1'b0;
        wr_ack  = 1'b0;
        if (bus_wr) begin
            case (bus_addr)
                OFS_DIV0:  wr_div[0]  = 1'b1;
                OFS_DIV1:  wr_div[1]  = 1'b1;
                OFS_CTRL0: wr_ctrl[0] = 1'b1;
                OFS_CTRL1: wr_ctrl[1] = 1'b1;
                OFS_MASK:  wr_mask    = 1'b1;
                OFS_ACK:   wr_ack     = 1'b1;
                default:   ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_DIV0:   bus_rdata[DW-1:0]     = div_q[0];
            OFS_CNT0:   bus_rdata[DW-1:0]     = cnt_q[0];
            OFS_CTRL0:  bus_rdata[CTRL_W-1:0] = ctrl_q[0];
            OFS_DIV1:   bus_rdata[DW-1:0]     = div_q[1];
            OFS_CNT1:   bus_rdata[DW-1:0]     = cnt_q[1];
            OFS_CTRL1:  bus_rdata[CTRL_W-1:0] = ctrl_q[1];
            OFS_MASK:   bus_rdata[NUM_TMR-1:0] = mask_q;
            OFS_MASKED: bus_rdata[NUM_TMR-1:0] = masked;
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dtmr_counter.sv
module dtmr_counter
    import dtmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_div,
    input  logic                wr_ctrl,
    input  logic [DW-1:0]       wdata_div,
    input  logic [CTRL_W-1:0]   wdata_ctrl,
    input  logic [NUM_SRC-1:0]  src_tick,
    output logic [DW-1:0]       div_q,
    output logic [CTRL_W-1:0]   ctrl_q,
    output logic [DW-1:0]       cnt_q,
    output logic                hit
);

    tctrl_t      ctrl_r;
    logic        step;
    logic        any_wr;
    logic [DW-1:0] one_v;

    assign one_v  = {{(DW-1){1'b0}}, 1'b1};
    assign any_wr = wr_div | wr_ctrl;
    assign step   = mode_runs(ctrl_r.mode) && strobe_of(ctrl_r.src, src_tick);
    assign hit    = step && !any_wr && (cnt_q == one_v);
    assign ctrl_q = ctrl_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            ctrl_r <= '0;
            cnt_q  <= '0;
        end else begin
            if (wr_div)
                div_q <= wdata_div;
            if (wr_ctrl)
                ctrl_r <= tctrl_t'(wdata_ctrl);
            if (any_wr) begin
                cnt_q <= wr_div ? wdata_div : div_q;
            end else if (step) begin
                if (cnt_q != '0)
                    cnt_q <= cnt_q - one_v;
                else if (ctrl_r.mode == RUN_REPEAT)
                    cnt_q <= div_q;
            end
        end
    end

endmodule

// File: rtl/dtmr_irq.sv
module dtmr_irq
    import dtmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_TMR-1:0] hit,
    input  logic               wr_mask,
    input  logic               wr_ack,
    input  logic [NUM_TMR-1:0] wbits,
    output logic [NUM_TMR-1:0] mask_q,
    output logic [NUM_TMR-1:0] raw_q,
    output logic [NUM_TMR-1:0] masked,
    output logic               irq
);

    logic [NUM_TMR-1:0] clr;

    assign clr    = wr_ack ? wbits : '0;
    assign masked = raw_q & mask_q;
    assign irq    = |masked;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clr) | hit;
            if (wr_mask)
                mask_q <= wbits;
        end
    end

endmodule

// File: rtl/dtmr_top.sv
module dtmr_top
    import dtmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [6:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [3:0]          src_tick,
    output logic                irq_out
);

    logic [NUM_TMR-1:0]             wr_div;
    logic [NUM_TMR-1:0]             wr_ctrl;
    logic                           wr_mask;
    logic                           wr_ack;
    logic [NUM_TMR-1:0][DW-1:0]     div_q;
    logic [NUM_TMR-1:0][DW-1:0]     cnt_q;
    logic [NUM_TMR-1:0][CTRL_W-1:0] ctrl_q;
    logic [NUM_TMR-1:0]             hit;
    logic [NUM_TMR-1:0]             mask_q;
    logic [NUM_TMR-1:0]             raw_q;
    logic [NUM_TMR-1:0]             masked;

    dtmr_regdec #(.DW(DW)) u_dec (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .wr_div    (wr_div),
        .wr_ctrl   (wr_ctrl),
        .wr_mask   (wr_mask),
        .wr_ack    (wr_ack),
        .div_q     (div_q),
        .cnt_q     (cnt_q),
        .ctrl_q    (ctrl_q),
        .mask_q    (mask_q),
        .masked    (masked),
        .bus_rdata (bus_rdata)
    );

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        dtmr_counter #(.DW(DW)) u_cnt (
            .clk        (clk),
            .rst        (rst),
            .wr_div     (wr_div[t]),
            .wr_ctrl    (wr_ctrl[t]),
            .wdata_div  (bus_wdata[DW-1:0]),
            .wdata_ctrl (bus_wdata[CTRL_W-1:0]),
            .src_tick   (src_tick),
            .div_q      (div_q[t]),
            .ctrl_q     (ctrl_q[t]),
            .cnt_q      (cnt_q[t]),
            .hit        (hit[t])
        );
    end

    dtmr_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .hit     (hit),
        .wr_mask (wr_mask),
        .wr_ack  (wr_ack),
        .wbits   (bus_wdata[NUM_TMR-1:0]),
        .mask_q  (mask_q),
        .raw_q   (raw_q),
        .masked  (masked),
        .irq     (irq_out)
    );

endmodule

// File: rtl/dtmr_checker.sv
module dtmr_checker
    import dtmr_pkg::*;
#(
    parameter int DW = 32
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             irq_out,
    input logic [NUM_SRC-1:0]               src_tick,
    input logic [NUM_TMR-1:0]               wr_div,
    input logic [NUM_TMR-1:0]               wr_ctrl,
    input logic                             wr_ack,
    input logic [BUS_W-1:0]                 bus_wdata,
    input logic [NUM_TMR-1:0]               hit,
    input logic [NUM_TMR-1:0]               raw_q,
    input logic [NUM_TMR-1:0]               mask_q,
    input logic [NUM_TMR-1:0][DW-1:0]       cnt_q,
    input logic [NUM_TMR-1:0][CTRL_W-1:0]   ctrl_q
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (raw_q == '0 && mask_q == '0 && cnt_q == '0)); // R1

    AST_NO_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq_out); // R9

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_chk
        logic       quiet;
        logic       sel;
        logic [1:0] md;
        assign quiet = !wr_div[t] && !wr_ctrl[t];
        assign md    = ctrl_q[t][4:3];
        assign sel   = (ctrl_q[t][2] == 1'b1) && src_tick[ctrl_q[t][1:0]];

        AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
            (quiet && sel && (md == 2'd1 || md == 2'd2) && cnt_q[t] > 1)
            |=> (cnt_q[t] == $past(cnt_q[t]) - 1)); // R4

        AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (quiet && (md == 2'd0 || md == 2'd3)) |=> $stable(cnt_q[t])); // R5

        AST_SINGLE_RESTS: assert property (@(posedge clk) disable iff (rst)
            (quiet && md == 2'd2 && cnt_q[t] == '0) |=> (cnt_q[t] == '0)); // R7

        AST_RAW_SET: assert property (@(posedge clk) disable iff (rst)
            hit[t] |=> raw_q[t]); // R8

        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (wr_ack && bus_wdata[t] && !hit[t]) |=> !raw_q[t]); // R10
    end

endmodule

bind dtmr_top dtmr_checker #(.DW(DW)) u_dtmr_checker (
    .clk       (clk),
    .rst       (rst),
    .irq_out   (irq_out),
    .src_tick  (src_tick),
    .wr_div    (wr_div),
    .wr_ctrl   (wr_ctrl),
    .wr_ack    (wr_ack),
    .bus_wdata (bus_wdata),
    .hit       (hit),
    .raw_q     (raw_q),
    .mask_q    (mask_q),
    .cnt_q     (cnt_q),
    .ctrl_q    (ctrl_q)
);

// File: tb/dtmr_top_bench.sv
`timescale 1ns/1ps
module dtmr_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  src_tick = '0;
    logic        irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    dtmr_top u_dtmr_top (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_tick  (src_tick),
        .irq_out   (irq_out)
    );

    // op: 0 write, 1 read-and-compare, 2 strobe pulse (data = strobe bits)
    localparam int NV = 42;
    localparam logic [73:0] VEC [NV] = '{
        {2'd1, 8'h00, 32'h0,        32'h0},        // R1
        {2'd1, 8'h54, 32'h0,        32'h0},        // R1
        {2'd1, 8'h14, 32'h0,        32'h0},        // R1
        {2'd0, 8'h00, 32'h5,        32'h0},
        {2'd1, 8'h04, 32'h0,        32'h5},        // R3
        {2'd0, 8'h08, 32'h0C,       32'h0},
        {2'd1, 8'h08, 32'h0,        32'h0C},       // R2
        {2'd2, 8'h00, 32'h1,        32'h0},
        {2'd1, 8'h04, 32'h0,        32'h4},        // R4
        {2'd2, 8'h00, 32'h2,        32'h0},
        {2'd1, 8'h04, 32'h0,        32'h4},        // R4
        {2'd0, 8'h48, 32'h3,        32'h0},
        {2'd2, 8'h00, 32'h1,        32'h0},
        {2'd2, 8'h00, 32'h1,        32'h0},
        {2'd2, 8'h00, 32'h1,        32'h0},
        {2'd1, 8'h04, 32'h0,        32'h1},        // R4
        {2'd1, 8'h54, 32'h0,        32'h0},        // R6
        {2'd2, 8'h00, 32'h1,        32'h0},
        {2'd1, 8'h04, 32'h0,        32'h0},        // R6
        {2'd1, 8'h54, 32'h0,        32'h1},        // R6
        {2'd2, 8'h00, 32'h1,        32'h0},
        {2'd1, 8'h04, 32'h0,        32'h5},        // R6
        {2'd0, 8'h4C, 32'h1,        32'h0},
        {2'd1, 8'h54, 32'h0,        32'h0},        // R10
        {2'd0, 8'h10, 32'h2,        32'h0},
        {2'd0, 8'h18, 32'h17,       32'h0},
        {2'd1, 8'h14, 32'h0,        32'h2},        // R3
        {2'd2, 8'h00, 32'h8,        32'h0},
        {2'd2, 8'h00, 32'h8,        32'h0},
        {2'd1, 8'h54, 32'h0,        32'h2},        // R8
        {2'd2, 8'h00, 32'h8,        32'h0},
        {2'd1, 8'h14, 32'h0,        32'h0},        // R7
        {2'd1, 8'h04, 32'h0,        32'h5},        // R8
        {2'd0, 8'h48, 32'h1,        32'h0},
        {2'd1, 8'h54, 32'h0,        32'h0},        // R9
        {2'd0, 8'h20, 32'hFFFF,     32'h0},
        {2'd1, 8'h20, 32'h0,        32'h0},        // R11
        {2'd1, 8'h00, 32'h0,        32'h5},        // R11
        {2'd0, 8'h08, 32'hFFFFFFE4, 32'h0},
        {2'd1, 8'h08, 32'h0,        32'h4},        // R2
        {2'd2, 8'h00, 32'h1,        32'h0},
        {2'd1, 8'h04, 32'h0,        32'h5}         // R5
    };
    localparam int TAG [NV] = '{1,1,1,0,3,0,2,0,4,0,4,0,0,0,0,4,6,0,6,6,0,6,
                                0,10,0,0,3,0,0,8,0,7,8,0,9,0,11,11,0,2,0,5};

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic tick(input logic [3:0] m);
        @(negedge clk);
        src_tick = m;
        @(negedge clk);
        src_tick = '0;
    endtask

    task automatic rd(input string req, input logic [6:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rd("R1", 7'h08, 32'h0);
        chk("R1", {31'b0, irq_out}, 32'h0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][73:72])
                2'd0: wr(VEC[i][70:64], VEC[i][63:32]);
                2'd1: rd($sformatf("R%0d vec %0d", TAG[i], i), VEC[i][70:64], VEC[i][31:0]);
                default: tick(VEC[i][35:32]);
            endcase
        end

        // R9: mask 1, raw 2 -> line low; open mask -> high
        chk("R9", {31'b0, irq_out}, 32'h0);
        wr(7'h48, 32'h3);
        chk("R9", {31'b0, irq_out}, 32'h1);
        rd("R9", 7'h54, 32'h2);
        // R10: acknowledge bit 1
        wr(7'h4C, 32'h2);
        rd("R10", 7'h54, 32'h0);
        chk("R10", {31'b0, irq_out}, 32'h0);
        // R10: terminal count and acknowledge in the same cycle, set wins
        wr(7'h00, 32'h1);
        wr(7'h08, 32'h0C);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 7'h4C; bus_wdata = 32'h1; src_tick = 4'h1;
        @(negedge clk);
        bus_wr = 1'b0; src_tick = '0;
        rd("R10", 7'h54, 32'h1);
        chk("R10", {31'b0, irq_out}, 32'h1);
        // R5: reserved mode 3 holds the count
        wr(7'h08, 32'h1C);
        tick(4'hF);
        rd("R5", 7'h04, 32'h1);
        // R1: reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rd("R1", 7'h08, 32'h0);
        rd("R1", 7'h48, 32'h0);
        rd("R1", 7'h10, 32'h0);
        chk("R1", {31'b0, irq_out}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        rd("R1", 7'h54, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule